// File: doc/BRIEF.md
# Descriptor Ring Index Tracker

This block keeps the two ring pointers that an Ethernet DMA engine uses for its transmit and receive descriptor rings. Each ring has a programmable length, a produce pointer and a consume pointer. On the transmit ring, software fills descriptors and moves the produce pointer, while the MAC moves the consume pointer each time it finishes a descriptor. On the receive ring the roles swap: the MAC fills descriptors and moves the produce pointer, and software releases them by writing the consume pointer.

From the two pointers the block reports whether each ring is empty, full or partly filled. One slot always stays unused, so a full ring and an empty ring never look the same. A one-cycle finish pulse tells software that the hardware side has run out of work: the transmit ring has drained, or the receive ring has no free descriptor left. Two small decoders turn a descriptor control word and a receive status word into byte counts, because both store a length as count minus one.

Top module: `dma_ring_tracker`

## Requirements
- R1: After block reset, every pointer of both rings is 0, each ring's last-index value is 2**IDX_W-1 (the largest ring), and both finish pulses are low.
- R2: A write to a ring's last-index value (entry count minus one) with a non-zero value loads it and clears both pointers of that ring at the next edge. A write of 0 is ignored and changes nothing.
- R3: A software pointer write (transmit produce, receive consume) takes effect at the next edge if the value is not above the ring's last index. A larger value is ignored and the pointer keeps its value.
- R4: A hardware step moves the hardware pointer (transmit consume, receive produce) up by one at the next edge, wrapping from the last index to 0. The step is ignored on an empty transmit ring and on a full receive ring.
- R5: A ring is empty when produce equals consume. It is full when consume is one slot ahead of produce modulo the entry count, including consume 0 with produce at the last index. It is partial otherwise. Exactly one of the three flags is high.
- R6: The finish output is high for the one cycle after a hardware step that left the transmit ring empty, or left the receive ring full. It is low at every other time.
- R7: A ring reset clears both pointers of that ring at the next edge. It keeps the ring's last-index value and overrides every write and step to that ring in the same cycle. The other ring is unaffected.
- R8: The descriptor control decoder reports the fragment byte count as bits [SIZE_W-1:0] plus one, the interrupt request as bit 31 and the last-fragment flag as bit 30.
- R9: The receive status decoder reports the frame byte count as status bits [SIZE_W-1:0] plus one. It also reports the payload count, which is that count minus the 4 check-sequence bytes, floored at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Block reset, active low |
| tx_ring_rst | input | 1 | Transmit ring pointer reset |
| tx_last_wr | input | 1 | Transmit last-index write strobe |
| tx_last_wdata | input | IDX_W | Transmit entry count minus one |
| tx_prod_wr | input | 1 | Software transmit produce pointer write |
| tx_prod_wdata | input | IDX_W | New transmit produce pointer |
| tx_hw_step | input | 1 | MAC finished a transmit descriptor |
| tx_prod | output | IDX_W | Transmit produce pointer |
| tx_cons | output | IDX_W | Transmit consume pointer |
| tx_last | output | IDX_W | Transmit last index |
| tx_empty | output | 1 | Transmit ring empty |
| tx_full | output | 1 | Transmit ring full |
| tx_partial | output | 1 | Transmit ring partly filled |
| tx_fin | output | 1 | Transmit finish pulse |
| rx_ring_rst | input | 1 | Receive ring pointer reset |
| rx_last_wr | input | 1 | Receive last-index write strobe |
| rx_last_wdata | input | IDX_W | Receive entry count minus one |
| rx_cons_wr | input | 1 | Software receive consume pointer write |
| rx_cons_wdata | input | IDX_W | New receive consume pointer |
| rx_hw_step | input | 1 | MAC filled a receive descriptor |
| rx_prod | output | IDX_W | Receive produce pointer |
| rx_cons | output | IDX_W | Receive consume pointer |
| rx_last | output | IDX_W | Receive last index |
| rx_empty | output | 1 | Receive ring empty |
| rx_full | output | 1 | Receive ring full |
| rx_partial | output | 1 | Receive ring partly filled |
| rx_fin | output | 1 | Receive finish pulse |
| desc_ctrl | input | 32 | Descriptor control word |
| desc_frag_bytes | output | SIZE_W+1 | Fragment byte count |
| desc_irq | output | 1 | Interrupt request flag |
| desc_last | output | 1 | Last fragment flag |
| rx_stat | input | 32 | Receive status word |
| rx_stat_bytes | output | SIZE_W+1 | Received byte count with check sequence |
| rx_payload_bytes | output | SIZE_W+1 | Received byte count without check sequence |

## Verification
The bench builds the block with IDX_W set to 3, so the largest ring has eight entries. With that size, wrap-around, the full condition at consume 0 and both finish events all occur within a handful of steps. Random rewrites of the last index down to one give tiny rings. On those, out-of-range software writes are frequent, and the one-unused-slot rule governs almost every cycle. SIZE_W stays at 11, so random status words cover the floor-at-zero payload case for counts below four.

// File: rtl/ring_trk_pkg.sv
package ring_trk_pkg;

  typedef enum logic [1:0] {
    FILL_EMPTY   = 2'd0,
    FILL_PARTIAL = 2'd1,
    FILL_FULL    = 2'd2
  } ring_fill_e;

  localparam int DESC_IRQ_BIT  = 31;
  localparam int DESC_LAST_BIT = 30;
  localparam int FCS_BYTES     = 4;

endpackage

// File: rtl/ring_index_unit.sv
module ring_index_unit
  import ring_trk_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter bit HW_PRODUCES = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_rst,
  input  logic             last_wr,
  input  logic [IDX_W-1:0] last_wdata,
  input  logic             sw_wr,
  input  logic [IDX_W-1:0] sw_wdata,
  input  logic             hw_done,
  output logic [IDX_W-1:0] prod,
  output logic [IDX_W-1:0] cons,
  output logic [IDX_W-1:0] last,
  output ring_fill_e       fill,
  output logic             fin,
  output logic             hw_adv,
  output logic             sw_take
);

  localparam logic [IDX_W-1:0] LAST_RST = '1;
  localparam logic [IDX_W-1:0] ONE      = IDX_W'(1);

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] idx,
                                                input logic [IDX_W-1:0] lst);
    return (idx == lst) ? '0 : idx + ONE;
  endfunction

  function automatic ring_fill_e classify(input logic [IDX_W-1:0] p,
                                          input logic [IDX_W-1:0] c,
                                          input logic [IDX_W-1:0] lst);
    if (p == c) return FILL_EMPTY;
    if (((c == '0) && (p == lst)) || (c == p + ONE)) return FILL_FULL;
    return FILL_PARTIAL;
  endfunction

  logic [IDX_W-1:0] sw_q, hw_q, last_q;
  logic [IDX_W-1:0] sw_d, hw_d, prod_d, cons_d;
  logic             fin_q;
  logic             last_take, clear;
  logic             hw_blocked, fin_hit;
  ring_fill_e       fill_nxt;

  // ownership of the two pointers is chosen per ring
  if (HW_PRODUCES) begin : g_hw_prod
    assign prod       = hw_q;
    assign cons       = sw_q;
    assign prod_d     = hw_d;
    assign cons_d     = sw_d;
    assign hw_blocked = (fill == FILL_FULL);
    assign fin_hit    = (fill_nxt == FILL_FULL);
  end else begin : g_hw_cons
    assign prod       = sw_q;
    assign cons       = hw_q;
    assign prod_d     = sw_d;
    assign cons_d     = hw_d;
    assign hw_blocked = (fill == FILL_EMPTY);
    assign fin_hit    = (fill_nxt == FILL_EMPTY);
  end

  assign last      = last_q;
  assign fin       = fin_q;
  assign fill      = classify(prod, cons, last_q);
  assign fill_nxt  = classify(prod_d, cons_d, last_q);

  assign last_take = last_wr && (last_wdata != '0) && !ring_rst;
  assign clear     = ring_rst || last_take;
  assign hw_adv    = hw_done && !hw_blocked && !clear;
  assign sw_take   = sw_wr && (sw_wdata <= last_q) && !clear;

  assign hw_d = hw_adv  ? wrap_inc(hw_q, last_q) : hw_q;
  assign sw_d = sw_take ? sw_wdata               : sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= '0;
      hw_q   <= '0;
      last_q <= LAST_RST;
      fin_q  <= 1'b0;
    end else if (clear) begin
      sw_q   <= '0;
      hw_q   <= '0;
      fin_q  <= 1'b0;
      if (last_take) last_q <= last_wdata;
    end else begin
      sw_q   <= sw_d;
      hw_q   <= hw_d;
      fin_q  <= hw_adv && fin_hit;
    end
  end

endmodule

// File: rtl/desc_ctrl_decode.sv
module desc_ctrl_decode #(
  parameter int SIZE_W = 11
) (
  input  logic [SIZE_W-1:0] size_field,
  input  logic              irq_bit,
  input  logic              last_bit,
  output logic [SIZE_W:0]   frag_bytes,
  output logic              irq_req,
  output logic              last_frag
);

  function automatic logic [SIZE_W:0] count_of(input logic [SIZE_W-1:0] f);
    return {1'b0, f} + (SIZE_W+1)'(1);
  endfunction

  assign frag_bytes = count_of(size_field);
  assign irq_req    = irq_bit;
  assign last_frag  = last_bit;

endmodule

// File: rtl/rx_stat_decode.sv
module rx_stat_decode
  import ring_trk_pkg::*;
#(
  parameter int SIZE_W = 11
) (
  input  logic [SIZE_W-1:0] size_field,
  output logic [SIZE_W:0]   frame_bytes,
  output logic [SIZE_W:0]   payload_bytes
);

  localparam logic [SIZE_W:0] FCS_N = (SIZE_W+1)'(FCS_BYTES);

  function automatic logic [SIZE_W:0] count_of(input logic [SIZE_W-1:0] f);
    return {1'b0, f} + (SIZE_W+1)'(1);
  endfunction

  function automatic logic [SIZE_W:0] strip_fcs(input logic [SIZE_W:0] n);
    return (n >= FCS_N) ? n - FCS_N : '0;
  endfunction

  assign frame_bytes   = count_of(size_field);
  assign payload_bytes = strip_fcs(frame_bytes);

endmodule

// File: rtl/dma_ring_tracker.sv
module dma_ring_tracker
  import ring_trk_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_ring_rst,
  input  logic              tx_last_wr,
  input  logic [IDX_W-1:0]  tx_last_wdata,
  input  logic              tx_prod_wr,
  input  logic [IDX_W-1:0]  tx_prod_wdata,
  input  logic              tx_hw_step,
  output logic [IDX_W-1:0]  tx_prod,
  output logic [IDX_W-1:0]  tx_cons,
  output logic [IDX_W-1:0]  tx_last,
  output logic              tx_empty,
  output logic              tx_full,
  output logic              tx_partial,
  output logic              tx_fin,
  input  logic              rx_ring_rst,
  input  logic              rx_last_wr,
  input  logic [IDX_W-1:0]  rx_last_wdata,
  input  logic              rx_cons_wr,
  input  logic [IDX_W-1:0]  rx_cons_wdata,
  input  logic              rx_hw_step,
  output logic [IDX_W-1:0]  rx_prod,
  output logic [IDX_W-1:0]  rx_cons,
  output logic [IDX_W-1:0]  rx_last,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              rx_partial,
  output logic              rx_fin,
  input  logic [31:0]       desc_ctrl,
  output logic [SIZE_W:0]   desc_frag_bytes,
  output logic              desc_irq,
  output logic              desc_last,
  input  logic [31:0]       rx_stat,
  output logic [SIZE_W:0]   rx_stat_bytes,
  output logic [SIZE_W:0]   rx_payload_bytes
);

  localparam int NRING = 2;

  logic [NRING-1:0] r_rst, r_last_wr, r_sw_wr, r_hw_done, r_fin;
  logic [NRING-1:0] ring_hw_adv, ring_sw_take;
  logic [IDX_W-1:0] r_last_wd [NRING];
  logic [IDX_W-1:0] r_sw_wd   [NRING];
  logic [IDX_W-1:0] r_prod    [NRING];
  logic [IDX_W-1:0] r_cons    [NRING];
  logic [IDX_W-1:0] r_last    [NRING];
  ring_fill_e       r_fill    [NRING];

  // ring 0 = transmit (software produces), ring 1 = receive (hardware produces)
  assign r_rst     = {rx_ring_rst, tx_ring_rst};
  assign r_last_wr = {rx_last_wr,  tx_last_wr};
  assign r_sw_wr   = {rx_cons_wr,  tx_prod_wr};
  assign r_hw_done = {rx_hw_step,  tx_hw_step};
  assign r_last_wd[0] = tx_last_wdata;
  assign r_last_wd[1] = rx_last_wdata;
  assign r_sw_wd[0]   = tx_prod_wdata;
  assign r_sw_wd[1]   = rx_cons_wdata;

  for (genvar g = 0; g < NRING; g++) begin : g_ring
    ring_index_unit #(
      .IDX_W      (IDX_W),
      .HW_PRODUCES(g == 1)
    ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .ring_rst  (r_rst[g]),
      .last_wr   (r_last_wr[g]),
      .last_wdata(r_last_wd[g]),
      .sw_wr     (r_sw_wr[g]),
      .sw_wdata  (r_sw_wd[g]),
      .hw_done   (r_hw_done[g]),
      .prod      (r_prod[g]),
      .cons      (r_cons[g]),
      .last      (r_last[g]),
      .fill      (r_fill[g]),
      .fin       (r_fin[g]),
      .hw_adv    (ring_hw_adv[g]),
      .sw_take   (ring_sw_take[g])
    );
  end

  assign tx_prod    = r_prod[0];
  assign tx_cons    = r_cons[0];
  assign tx_last    = r_last[0];
  assign tx_empty   = (r_fill[0] == FILL_EMPTY);
  assign tx_full    = (r_fill[0] == FILL_FULL);
  assign tx_partial = (r_fill[0] == FILL_PARTIAL);
  assign tx_fin     = r_fin[0];

  assign rx_prod    = r_prod[1];
  assign rx_cons    = r_cons[1];
  assign rx_last    = r_last[1];
  assign rx_empty   = (r_fill[1] == FILL_EMPTY);
  assign rx_full    = (r_fill[1] == FILL_FULL);
  assign rx_partial = (r_fill[1] == FILL_PARTIAL);
  assign rx_fin     = r_fin[1];

  desc_ctrl_decode #(.SIZE_W(SIZE_W)) u_ctrl_dec (
    .size_field(desc_ctrl[SIZE_W-1:0]),
    .irq_bit   (desc_ctrl[DESC_IRQ_BIT]),
    .last_bit  (desc_ctrl[DESC_LAST_BIT]),
    .frag_bytes(desc_frag_bytes),
    .irq_req   (desc_irq),
    .last_frag (desc_last)
  );

  rx_stat_decode #(.SIZE_W(SIZE_W)) u_stat_dec (
    .size_field   (rx_stat[SIZE_W-1:0]),
    .frame_bytes  (rx_stat_bytes),
    .payload_bytes(rx_payload_bytes)
  );

endmodule

// File: rtl/ring_trk_chk.sv
module ring_trk_chk #(
  parameter int IDX_W  = 4,
  parameter int SIZE_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_ring_rst,
  input logic             tx_last_wr,
  input logic [IDX_W-1:0] tx_prod_wdata,
  input logic             tx_hw_step,
  input logic [IDX_W-1:0] tx_prod,
  input logic [IDX_W-1:0] tx_cons,
  input logic [IDX_W-1:0] tx_last,
  input logic             tx_empty,
  input logic             tx_full,
  input logic             tx_partial,
  input logic             tx_fin,
  input logic             rx_ring_rst,
  input logic             rx_last_wr,
  input logic [IDX_W-1:0] rx_cons_wdata,
  input logic             rx_hw_step,
  input logic [IDX_W-1:0] rx_prod,
  input logic [IDX_W-1:0] rx_cons,
  input logic [IDX_W-1:0] rx_last,
  input logic             rx_empty,
  input logic             rx_full,
  input logic             rx_partial,
  input logic             rx_fin,
  input logic [1:0]       hw_adv,
  input logic [1:0]       sw_take,
  input logic [31:0]      desc_ctrl,
  input logic [SIZE_W:0]  desc_frag_bytes,
  input logic             desc_irq,
  input logic             desc_last,
  input logic [31:0]      rx_stat,
  input logic [SIZE_W:0]  rx_stat_bytes,
  input logic [SIZE_W:0]  rx_payload_bytes
);

  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  // R2
  last_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_last != '0) && (rx_last != '0));

  // R3
  tx_sw_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_take[0] |=> tx_prod == $past(tx_prod_wdata));

  // R3
  rx_sw_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_take[1] |=> rx_cons == $past(rx_cons_wdata));

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_prod <= tx_last) && (tx_cons <= tx_last) && (rx_prod <= rx_last) && (rx_cons <= rx_last));

  // R4
  tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_adv[0] |=> tx_cons == (($past(tx_cons) == $past(tx_last)) ? '0 : $past(tx_cons) + ONE));

  // R4
  rx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_adv[1] |=> rx_prod == (($past(rx_prod) == $past(rx_last)) ? '0 : $past(rx_prod) + ONE));

  // R4
  hw_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hw_adv[0] && tx_empty)) && (!(hw_adv[1] && rx_full)));

  // R4
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_hw_step && !tx_ring_rst && !tx_last_wr) |=> $stable(tx_cons));

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_hw_step && !rx_ring_rst && !rx_last_wr) |=> $stable(rx_prod));

  // R5
  fill_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({tx_empty, tx_full, tx_partial}) == 1) &&
    ($countones({rx_empty, rx_full, rx_partial}) == 1));

  // R6
  tx_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fin |-> (tx_empty && $past(hw_adv[0])));

  // R6
  rx_fin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fin |-> (rx_full && $past(hw_adv[1])));

  // R7
  tx_ring_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ring_rst |=> ((tx_prod == '0) && (tx_cons == '0) && $stable(tx_last)));

  // R7
  rx_ring_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ring_rst |=> ((rx_prod == '0) && (rx_cons == '0) && $stable(rx_last)));

  // R8
  frag_pure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(desc_ctrl) |-> $stable({desc_frag_bytes, desc_irq, desc_last}));

  // R8
  frag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    desc_frag_bytes != '0);

  // R9
  stat_pure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(rx_stat) |-> $stable({rx_stat_bytes, rx_payload_bytes}));

  // R9
  payload_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_payload_bytes < rx_stat_bytes);

endmodule

bind dma_ring_tracker ring_trk_chk #(.IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_ring_trk_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .tx_ring_rst     (tx_ring_rst),
  .tx_last_wr      (tx_last_wr),
  .tx_prod_wdata   (tx_prod_wdata),
  .tx_hw_step      (tx_hw_step),
  .tx_prod         (tx_prod),
  .tx_cons         (tx_cons),
  .tx_last         (tx_last),
  .tx_empty        (tx_empty),
  .tx_full         (tx_full),
  .tx_partial      (tx_partial),
  .tx_fin          (tx_fin),
  .rx_ring_rst     (rx_ring_rst),
  .rx_last_wr      (rx_last_wr),
  .rx_cons_wdata   (rx_cons_wdata),
  .rx_hw_step      (rx_hw_step),
  .rx_prod         (rx_prod),
  .rx_cons         (rx_cons),
  .rx_last         (rx_last),
  .rx_empty        (rx_empty),
  .rx_full         (rx_full),
  .rx_partial      (rx_partial),
  .rx_fin          (rx_fin),
  .hw_adv          (ring_hw_adv),
  .sw_take         (ring_sw_take),
  .desc_ctrl       (desc_ctrl),
  .desc_frag_bytes (desc_frag_bytes),
  .desc_irq        (desc_irq),
  .desc_last       (desc_last),
  .rx_stat         (rx_stat),
  .rx_stat_bytes   (rx_stat_bytes),
  .rx_payload_bytes(rx_payload_bytes)
);

// File: tb/test_dma_ring_tracker.sv
module test_dma_ring_tracker;

  localparam int IW = 3;
  localparam int SW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_ring_rst, tx_last_wr, tx_prod_wr, tx_hw_step;
  logic [IW-1:0] tx_last_wdata, tx_prod_wdata;
  logic [IW-1:0] tx_prod, tx_cons, tx_last;
  logic tx_empty, tx_full, tx_partial, tx_fin;
  logic rx_ring_rst, rx_last_wr, rx_cons_wr, rx_hw_step;
  logic [IW-1:0] rx_last_wdata, rx_cons_wdata;
  logic [IW-1:0] rx_prod, rx_cons, rx_last;
  logic rx_empty, rx_full, rx_partial, rx_fin;
  logic [31:0] desc_ctrl, rx_stat;
  logic [SW:0] desc_frag_bytes, rx_stat_bytes, rx_payload_bytes;
  logic desc_irq, desc_last;

  always #4 clk = ~clk;

  dma_ring_tracker #(.IDX_W(IW), .SIZE_W(SW)) i_dma_ring_tracker (
    .clk(clk), .rst_n(rst_n),
    .tx_ring_rst(tx_ring_rst), .tx_last_wr(tx_last_wr), .tx_last_wdata(tx_last_wdata),
    .tx_prod_wr(tx_prod_wr), .tx_prod_wdata(tx_prod_wdata), .tx_hw_step(tx_hw_step),
    .tx_prod(tx_prod), .tx_cons(tx_cons), .tx_last(tx_last),
    .tx_empty(tx_empty), .tx_full(tx_full), .tx_partial(tx_partial), .tx_fin(tx_fin),
    .rx_ring_rst(rx_ring_rst), .rx_last_wr(rx_last_wr), .rx_last_wdata(rx_last_wdata),
    .rx_cons_wr(rx_cons_wr), .rx_cons_wdata(rx_cons_wdata), .rx_hw_step(rx_hw_step),
    .rx_prod(rx_prod), .rx_cons(rx_cons), .rx_last(rx_last),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_partial(rx_partial), .rx_fin(rx_fin),
    .desc_ctrl(desc_ctrl), .desc_frag_bytes(desc_frag_bytes),
    .desc_irq(desc_irq), .desc_last(desc_last),
    .rx_stat(rx_stat), .rx_stat_bytes(rx_stat_bytes), .rx_payload_bytes(rx_payload_bytes)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model: index 0 = transmit, 1 = receive
  int  m_prod [2];
  int  m_cons [2];
  int  m_last [2];
  bit  m_fin  [2];

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_ring(input int r, input bit rst, input bit lwr, input int lwd,
                            input bit swwr, input int swd, input bit hw);
    int  n;
    bit  emp, ful, adv, ok;
    int  np, nc;
    if (rst) begin
      m_prod[r] = 0; m_cons[r] = 0; m_fin[r] = 0;
      return;
    end
    if (lwr && lwd != 0) begin
      m_last[r] = lwd; m_prod[r] = 0; m_cons[r] = 0; m_fin[r] = 0;
      return;
    end
    n   = m_last[r] + 1;
    emp = (m_prod[r] == m_cons[r]);
    ful = (((m_prod[r] + 1) % n) == m_cons[r]);
    ok  = swwr && (swd <= m_last[r]);
    if (r == 0) begin
      adv = hw && !emp;
      nc  = adv ? (m_cons[r] + 1) % n : m_cons[r];
      np  = ok ? swd : m_prod[r];
      m_fin[r] = adv && (np == nc);
    end else begin
      adv = hw && !ful;
      np  = adv ? (m_prod[r] + 1) % n : m_prod[r];
      nc  = ok ? swd : m_cons[r];
      m_fin[r] = adv && (((np + 1) % n) == nc);
    end
    m_prod[r] = np;
    m_cons[r] = nc;
  endtask

  task automatic compare_ring(input int r, input int p, input int c, input int l,
                              input bit e, input bit f, input bit pa, input bit fi);
    int  n;
    bit  xe, xf;
    string nm;
    nm = (r == 0) ? "tx" : "rx";
    n  = m_last[r] + 1;
    xe = (m_prod[r] == m_cons[r]);
    xf = (((m_prod[r] + 1) % n) == m_cons[r]);
    check("R3 R4", {nm, " prod"}, p, m_prod[r]);
    check("R3 R4", {nm, " cons"}, c, m_cons[r]);
    check("R2", {nm, " last"}, l, m_last[r]);
    check("R5", {nm, " empty"}, int'(e), int'(xe));
    check("R5", {nm, " full"}, int'(f), int'(xf));
    check("R5", {nm, " partial"}, int'(pa), int'(!xe && !xf));
    check("R6", {nm, " fin"}, int'(fi), int'(m_fin[r]));
  endtask

  task automatic compare_decode();
    int fb, sb, pb;
    fb = int'(desc_ctrl[10:0]) + 1;
    sb = int'(rx_stat[10:0]) + 1;
    pb = (sb >= 4) ? sb - 4 : 0;
    check("R8", "frag bytes", int'(desc_frag_bytes), fb);
    check("R8", "irq flag", int'(desc_irq), int'(desc_ctrl[31]));
    check("R8", "last flag", int'(desc_last), int'(desc_ctrl[30]));
    check("R9", "frame bytes", int'(rx_stat_bytes), sb);
    check("R9", "payload bytes", int'(rx_payload_bytes), pb);
  endtask

  task automatic clear_inputs();
    tx_ring_rst = 0; tx_last_wr = 0; tx_prod_wr = 0; tx_hw_step = 0;
    rx_ring_rst = 0; rx_last_wr = 0; rx_cons_wr = 0; rx_hw_step = 0;
  endtask

  // one clock: model follows the inputs at the edge, outputs compared at the falling edge
  task automatic tick();
    @(posedge clk);
    model_ring(0, tx_ring_rst, tx_last_wr, int'(tx_last_wdata), tx_prod_wr, int'(tx_prod_wdata), tx_hw_step);
    model_ring(1, rx_ring_rst, rx_last_wr, int'(rx_last_wdata), rx_cons_wr, int'(rx_cons_wdata), rx_hw_step);
    @(negedge clk);
    compare_ring(0, int'(tx_prod), int'(tx_cons), int'(tx_last), tx_empty, tx_full, tx_partial, tx_fin);
    compare_ring(1, int'(rx_prod), int'(rx_cons), int'(rx_last), rx_empty, rx_full, rx_partial, rx_fin);
    compare_decode();
    clear_inputs();
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    tx_last_wdata = '0; tx_prod_wdata = '0; rx_last_wdata = '0; rx_cons_wdata = '0;
    desc_ctrl = 32'hC000_05DB; rx_stat = 32'h0000_0002;
    for (int r = 0; r < 2; r++) begin
      m_prod[r] = 0; m_cons[r] = 0; m_last[r] = 7; m_fin[r] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", "tx prod reset", int'(tx_prod), 0);
    check("R1", "tx last reset", int'(tx_last), 7);
    check("R1", "rx cons reset", int'(rx_cons), 0);
    check("R1", "rx last reset", int'(rx_last), 7);
    check("R1", "fin reset", int'(tx_fin | rx_fin), 0);
    compare_decode();
    rst_n = 1'b1;

    // R3 software publishes three transmit descriptors
    tx_prod_wr = 1; tx_prod_wdata = 3; tick();
    // R4 R6 hardware drains them, finish on the third
    for (int k = 0; k < 3; k++) begin tx_hw_step = 1; tick(); end
    check("R6", "tx fin after drain", int'(tx_fin), 1);
    check("R4", "tx cons after drain", int'(tx_cons), 3);
    // R4 step on empty ring ignored
    tx_hw_step = 1; tick();
    check("R4", "tx cons hold on empty", int'(tx_cons), 3);
    check("R6", "tx fin one cycle", int'(tx_fin), 0);
    // R2 shrink to four entries
    tx_last_wr = 1; tx_last_wdata = 3; tick();
    check("R2", "tx last loaded", int'(tx_last), 3);
    check("R2", "tx cons cleared", int'(tx_cons), 0);
    // R3 out-of-range write ignored
    tx_prod_wr = 1; tx_prod_wdata = 5; tick();
    check("R3", "tx prod ignored", int'(tx_prod), 0);
    // R5 wrap-case full
    tx_prod_wr = 1; tx_prod_wdata = 3; tick();
    check("R5", "tx full wrap", int'(tx_full), 1);
    // R2 zero size write ignored
    tx_last_wr = 1; tx_last_wdata = 0; tick();
    check("R2", "tx last kept", int'(tx_last), 3);
    check("R2", "tx prod kept", int'(tx_prod), 3);
    // R4 R6 receive fills until full
    for (int k = 0; k < 7; k++) begin rx_hw_step = 1; tick(); end
    check("R6", "rx fin on full", int'(rx_fin), 1);
    rx_hw_step = 1; tick();
    check("R4", "rx prod hold on full", int'(rx_prod), 7);
    // R7 ring reset beats writes, other ring untouched
    rx_ring_rst = 1; rx_cons_wr = 1; rx_cons_wdata = 2; rx_last_wr = 1; rx_last_wdata = 2;
    rx_hw_step = 1; tick();
    check("R7", "rx prod cleared", int'(rx_prod), 0);
    check("R7", "rx last kept", int'(rx_last), 7);
    check("R7", "tx prod untouched", int'(tx_prod), 3);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      tx_ring_rst   = ($urandom % 97) == 0;
      rx_ring_rst   = ($urandom % 97) == 0;
      tx_last_wr    = ($urandom % 40) == 0;
      rx_last_wr    = ($urandom % 40) == 0;
      tx_last_wdata = IW'($urandom % 8);
      rx_last_wdata = IW'($urandom % 8);
      tx_prod_wr    = ($urandom % 3) == 0;
      rx_cons_wr    = ($urandom % 4) == 0;
      tx_prod_wdata = IW'($urandom % 8);
      rx_cons_wdata = IW'($urandom % 8);
      tx_hw_step    = ($urandom % 2) == 0;
      rx_hw_step    = ($urandom % 3) != 0;
      desc_ctrl     = $urandom;
      rx_stat       = (($urandom % 4) == 0) ? ($urandom % 6) : $urandom;
      tick();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule